// File: doc/BRIEF.md
# Fixed-Point State-Variable Filter Core

This block holds the three node values of a two-integrator-loop state-variable filter (highpass, bandpass, lowpass) as signed fixed-point registers. On each update the two integrators step first, using the node values held before the update. The highpass node is then recomputed from the new bandpass and lowpass values, the resonance coefficient and the input sample. All coefficients come in on ports. Mapping register settings to cutoff or resonance values is done outside this block.

There are two ways to advance the filter. A single-step strobe applies one clock of elapsed time with the fine cutoff coefficient. A start request with an elapsed-cycle count applies a longer stretch of time. The block cuts the count into chunks of at most `CHUNK_MAX` cycles and processes one chunk per clock. Each chunk scales the coarse cutoff coefficient by its own length. A filter-enable input held low zeroes the nodes, and a synchronous reset clears everything.

Top module: `svf_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, `vhp`, `vbp`, `vlp`, `busy` and `done` all become 0.
- R2: A `step_strobe` accepted while idle and enabled updates `vbp` to vbp-((w0*vhp)>>>20) and `vlp` to vlp-((w0*vbp)>>>20). Both products use the node values from before that edge. The result is visible after the same edge.
- R3: After the integrators are updated, `vhp` becomes ((new vbp * q_coef)>>>10) - new vlp - vi. The wrap is two's complement at `DATA_W` bits, and `w0`, `w0_dt_coef` and `q_coef` are unsigned.
- R4: An accepted `start` with count N>0 latches `vi`, `w0_dt_coef`, `q_coef` and N, and raises `busy` after that edge. Each following clock processes one chunk of min(remaining, 8) cycles, so `busy` is high for exactly ceil(N/8) clocks.
- R5: A chunk of length L uses gain g=(w0_dt_coef*L)>>6. Its deltas are (g*vhp)>>>14 and (g*vbp)>>>14, and the rest of the update follows R2 and R3.
- R6: While `enable` is low at an edge, all three nodes become 0 and any run in progress is dropped: `busy` goes to 0 and no `done` pulse follows.
- R7: While `busy` is high, `start` and `step_strobe` are ignored. A `step_strobe` in the same cycle as an accepted `start` is also ignored.
- R8: Every right shift is arithmetic, so a negative product rounds toward minus infinity. For example, with q_coef=1023, a bandpass value of -2 contributes -2 to `vhp`.
- R9: `done` is high for one clock right after the last chunk. An accepted `start` with N=0 raises `done` after that edge and changes no node.
- R10: When no update is accepted and `enable` is high, all three nodes hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous clear, active high |
| enable | input | 1 | Filter enable; low zeroes the nodes |
| vi | input | DATA_W | Signed input sample |
| w0 | input | W0_W | Unsigned cutoff gain for single steps |
| w0_dt_coef | input | WDT_W | Unsigned cutoff gain per cycle for chunked runs |
| q_coef | input | Q_W | Unsigned resonance coefficient, 1024/Q |
| step_strobe | input | 1 | Request one single-cycle update |
| start | input | 1 | Request a chunked run of `cycles` cycles |
| cycles | input | CNT_W | Elapsed cycle count for a run |
| busy | output | 1 | A chunked run is in progress |
| done | output | 1 | One-clock pulse ending a run |
| vhp | output | DATA_W | Highpass node, signed |
| vbp | output | DATA_W | Bandpass node, signed |
| vlp | output | DATA_W | Lowpass node, signed |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that `start`, `step_strobe` and `enable` change only between edges, so the chunk counter always starts from a known value. The bench keeps to this: it holds reset for the first cycles and changes every input on the falling edge. It reads results one edge after an update or once `busy` has fallen. Node values are compared against a 64-bit model that applies the same wrap, so coefficient magnitudes do not need to stay small.

// File: rtl/svf_pkg.sv
package svf_pkg;

   function automatic int svf_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int unsigned SVF_FINE_SHIFT  = 20;
   localparam int unsigned SVF_DT_SHIFT    = 6;
   localparam int unsigned SVF_CHUNK_SHIFT = 14;
   localparam int unsigned SVF_Q_SHIFT     = 10;

   typedef enum logic {
      STEP_FINE  = 1'b0,
      STEP_CHUNK = 1'b1
   } svf_step_e;

endpackage

// File: rtl/svf_seq.sv
module svf_seq #(
   parameter int CNT_W     = 16,
   parameter int CHUNK_MAX = 8,
   parameter int LEN_W     = $clog2(CHUNK_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enable,
   input  logic             start,
   input  logic [CNT_W-1:0] cycles,
   output logic             accept,
   output logic             busy,
   output logic             done,
   output logic [LEN_W-1:0] chunk_len
);
   localparam logic [CNT_W-1:0] CHUNK_C = CNT_W'(CHUNK_MAX);

   logic [CNT_W-1:0] remain;
   logic             last;

   if (CHUNK_MAX < 1) begin : g_bad_chunk
      $error("svf_seq: CHUNK_MAX must be at least 1");
   end
   if (CNT_W < LEN_W) begin : g_bad_cnt
      $error("svf_seq: CNT_W too narrow for CHUNK_MAX");
   end

   assign accept    = start && !busy && enable;
   assign last      = (remain <= CHUNK_C);
   assign chunk_len = last ? LEN_W'(remain) : LEN_W'(CHUNK_MAX);

   always_ff @(posedge clk) begin
      if (rst || !enable) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         remain <= '0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            remain <= remain - CNT_W'(chunk_len);
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end else if (accept) begin
            if (cycles == '0) begin
               done <= 1'b1;
            end else begin
               busy   <= 1'b1;
               remain <= cycles;
            end
         end
      end
   end

   assert_chunk_bounds_R4: assert property (@(posedge clk) disable iff (rst)
      busy |-> (chunk_len != '0) && (chunk_len <= LEN_W'(CHUNK_MAX)));

   assert_run_progress_R7: assert property (@(posedge clk) disable iff (rst)
      (busy && enable) |=> (!busy || (remain < $past(remain))));

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);

   assert_done_on_finish_R9: assert property (@(posedge clk) disable iff (rst)
      ($fell(busy) && $past(enable) && !$past(rst)) |-> done);

endmodule

// File: rtl/svf_integ.sv
module svf_integ #(
   parameter int DATA_W = 32,
   parameter int GAIN_W = 25,
   parameter int PROD_W = 58,
   parameter int SH_A   = 20,
   parameter int SH_B   = 14
) (
   input  logic signed [DATA_W-1:0] state_i,
   input  logic signed [DATA_W-1:0] drive_i,
   input  logic signed [GAIN_W-1:0] gain_i,
   input  logic                     sel_b,
   output logic signed [DATA_W-1:0] next_o
);
   logic signed [PROD_W-1:0] prod;

   if (PROD_W < DATA_W + GAIN_W) begin : g_bad_prod
      $error("svf_integ: PROD_W too narrow for the product");
   end
   if (SH_A >= PROD_W || SH_B >= PROD_W) begin : g_bad_shift
      $error("svf_integ: shift exceeds product width");
   end

   always_comb begin
      prod   = PROD_W'(gain_i) * PROD_W'(drive_i);
      next_o = state_i - DATA_W'(sel_b ? (prod >>> SH_B) : (prod >>> SH_A));
   end

endmodule

// File: rtl/svf_core.sv
module svf_core
   import svf_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int W0_W      = 24,
   parameter int WDT_W     = 16,
   parameter int Q_W       = 16,
   parameter int CNT_W     = 16,
   parameter int CHUNK_MAX = 8
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     enable,
   input  logic signed [DATA_W-1:0] vi,
   input  logic [W0_W-1:0]          w0,
   input  logic [WDT_W-1:0]         w0_dt_coef,
   input  logic [Q_W-1:0]           q_coef,
   input  logic                     step_strobe,
   input  logic                     start,
   input  logic [CNT_W-1:0]         cycles,
   output logic                     busy,
   output logic                     done,
   output logic signed [DATA_W-1:0] vhp,
   output logic signed [DATA_W-1:0] vbp,
   output logic signed [DATA_W-1:0] vlp
);
   localparam int LEN_W  = $clog2(CHUNK_MAX + 1);
   localparam int DT_W   = WDT_W + LEN_W;
   localparam int GAIN_W = svf_max(W0_W, DT_W) + 1;
   localparam int PROD_W = DATA_W + svf_max(GAIN_W, Q_W + 1) + 1;

   if (DATA_W < 8) begin : g_bad_data
      $error("svf_core: DATA_W must be at least 8");
   end
   if (W0_W < 1 || WDT_W < 1 || Q_W < 1) begin : g_bad_coef
      $error("svf_core: coefficient widths must be positive");
   end

   logic                     accept;
   logic [LEN_W-1:0]         chunk_len;
   logic                     fine_fire;
   logic                     do_update;
   svf_step_e                step_kind;

   logic signed [DATA_W-1:0] vi_lat;
   logic [WDT_W-1:0]         wdt_lat;
   logic [Q_W-1:0]           q_lat;

   logic signed [DATA_W-1:0] vi_sel;
   logic [Q_W-1:0]           q_sel;
   logic [DT_W-1:0]          dt_full;
   logic signed [GAIN_W-1:0] gain;

   logic signed [DATA_W-1:0] st_cur [2];
   logic signed [DATA_W-1:0] st_drv [2];
   logic signed [DATA_W-1:0] st_nxt [2];
   logic signed [PROD_W-1:0] qp;
   logic signed [DATA_W-1:0] hp_next;

   svf_seq #(
      .CNT_W     (CNT_W),
      .CHUNK_MAX (CHUNK_MAX),
      .LEN_W     (LEN_W)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .enable    (enable),
      .start     (start),
      .cycles    (cycles),
      .accept    (accept),
      .busy      (busy),
      .done      (done),
      .chunk_len (chunk_len)
   );

   // start takes priority over a same-cycle strobe
   assign fine_fire = enable && !busy && step_strobe && !start;
   assign do_update = busy || fine_fire;
   assign step_kind = busy ? STEP_CHUNK : STEP_FINE;

   always_ff @(posedge clk) begin
      if (rst) begin
         vi_lat  <= '0;
         wdt_lat <= '0;
         q_lat   <= '0;
      end else if (accept) begin
         vi_lat  <= vi;
         wdt_lat <= w0_dt_coef;
         q_lat   <= q_coef;
      end
   end

   always_comb begin
      vi_sel  = (step_kind == STEP_CHUNK) ? vi_lat : vi;
      q_sel   = (step_kind == STEP_CHUNK) ? q_lat  : q_coef;
      dt_full = DT_W'(wdt_lat) * DT_W'(chunk_len);
      if (step_kind == STEP_CHUNK) gain = GAIN_W'(dt_full >> SVF_DT_SHIFT);
      else                         gain = GAIN_W'(w0);
   end

   // integrator 0: bandpass driven by highpass; integrator 1: lowpass driven by bandpass
   assign st_cur[0] = vbp;
   assign st_drv[0] = vhp;
   assign st_cur[1] = vlp;
   assign st_drv[1] = vbp;

   for (genvar gi = 0; gi < 2; gi++) begin : g_integ
      svf_integ #(
         .DATA_W (DATA_W),
         .GAIN_W (GAIN_W),
         .PROD_W (PROD_W),
         .SH_A   (SVF_FINE_SHIFT),
         .SH_B   (SVF_CHUNK_SHIFT)
      ) u_integ (
         .state_i (st_cur[gi]),
         .drive_i (st_drv[gi]),
         .gain_i  (gain),
         .sel_b   (step_kind == STEP_CHUNK),
         .next_o  (st_nxt[gi])
      );
   end

   always_comb begin
      qp      = PROD_W'(st_nxt[0]) * $signed(PROD_W'(q_sel));
      hp_next = DATA_W'(qp >>> SVF_Q_SHIFT) - st_nxt[1] - vi_sel;
   end

   always_ff @(posedge clk) begin
      if (rst || !enable) begin
         vhp <= '0;
         vbp <= '0;
         vlp <= '0;
      end else if (do_update) begin
         vbp <= st_nxt[0];
         vlp <= st_nxt[1];
         vhp <= hp_next;
      end
   end

   assert_disable_clears_R6: assert property (@(posedge clk) disable iff (rst)
      !enable |=> (vhp == '0) && (vbp == '0) && (vlp == '0) && !busy);

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (enable && !busy && !step_strobe) |=> ($stable(vhp) && $stable(vbp) && $stable(vlp)));

   assert_busy_blocks_strobe_R7: assert property (@(posedge clk) disable iff (rst)
      (busy && step_strobe) |-> !fine_fire);

endmodule

// File: tb/tb_svf_core.sv
module tb_svf_core;
   localparam int DW = 32;
   localparam int NV = 10;

   logic           clk = 1'b0;
   logic           rst;
   logic           enable;
   logic signed [DW-1:0] vi;
   logic [23:0]    w0;
   logic [15:0]    w0_dt_coef;
   logic [15:0]    q_coef;
   logic           step_strobe;
   logic           start;
   logic [15:0]    cycles;
   logic           busy, done;
   logic signed [DW-1:0] vhp, vbp, vlp;

   always #5 clk = ~clk;

   svf_core dut (
      .clk(clk), .rst(rst), .enable(enable), .vi(vi), .w0(w0),
      .w0_dt_coef(w0_dt_coef), .q_coef(q_coef), .step_strobe(step_strobe),
      .start(start), .cycles(cycles), .busy(busy), .done(done),
      .vhp(vhp), .vbp(vbp), .vlp(vlp)
   );

   // mode 0 = single step (gain in V_G is w0), 1 = chunked run (gain is w0_dt_coef)
   localparam int V_MODE [NV] = '{0, 0, 0, 1, 1, 1, 1, 0, 1, 0};
   localparam int V_VI   [NV] = '{1000, 1000, -3000, 500, 500, -2000, 0, 0, 12345, -7};
   localparam int V_G    [NV] = '{200000, 200000, 800000, 3000, 3000, 1200, 4000,
                                  1000000, 65535, 16777215};
   localparam int V_Q    [NV] = '{1400, 1400, 700, 1024, 1024, 1800, 600, 1024, 2048, 65535};
   localparam int V_N    [NV] = '{0, 0, 0, 8, 20, 1, 17, 0, 9, 0};

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   longint m_hp, m_bp, m_lp;

   function automatic longint wrap(input longint x);
      return longint'(int'(x));
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_step(input longint g, input int sh, input longint x, input longint q);
      longint dbp, dlp;
      dbp  = (g * m_hp) >>> sh;
      dlp  = (g * m_bp) >>> sh;
      m_bp = wrap(m_bp - dbp);
      m_lp = wrap(m_lp - dlp);
      m_hp = wrap(((m_bp * q) >>> 10) - m_lp - x);
   endtask

   task automatic model_run(input longint wdt, input int n, input longint x, input longint q);
      int rem;
      int len;
      rem = n;
      while (rem > 0) begin
         len = (rem > 8) ? 8 : rem;
         model_step((wdt * len) >>> 6, 14, x, q);
         rem -= len;
      end
   endtask

   task automatic chk_nodes(input string req);
      chk({req, " vhp"}, longint'(vhp), m_hp);
      chk({req, " vbp"}, longint'(vbp), m_bp);
      chk({req, " vlp"}, longint'(vlp), m_lp);
   endtask

   task automatic do_single(input int x, input int g, input int q);
      vi = x; w0 = 24'(g); q_coef = 16'(q); step_strobe = 1'b1;
      @(negedge clk);
      step_strobe = 1'b0;
   endtask

   // returns number of falling edges seen with busy high
   task automatic do_run(input int x, input int g, input int q, input int n, output int nbusy);
      vi = x; w0_dt_coef = 16'(g); q_coef = 16'(q); cycles = 16'(n); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      vi = 12; w0_dt_coef = 16'd999; q_coef = 16'd77; // latched values must be used
      nbusy = 0;
      while (busy && nbusy < 10000) begin
         nbusy++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int nb;
      rst = 1'b1; enable = 1'b1; vi = 0; w0 = 0; w0_dt_coef = 0; q_coef = 0;
      step_strobe = 0; start = 0; cycles = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 vhp", longint'(vhp), 0);
      chk("R1 vbp", longint'(vbp), 0);
      chk("R1 vlp", longint'(vlp), 0);
      chk("R1 busy", longint'(busy), 0);
      chk("R1 done", longint'(done), 0);
      rst = 1'b0;
      @(negedge clk);

      // R8 hand-computed floor of a negative product
      do_single(-5, 0, 1023);
      chk("R8 first vhp", longint'(vhp), 5);
      do_single(-5, 524288, 1023);
      chk("R8 vbp", longint'(vbp), -2);
      chk("R8 vlp", longint'(vlp), 0);
      chk("R8 vhp", longint'(vhp), 3);
      m_hp = 3; m_bp = -2; m_lp = 0;

      // vector table: R2 R3 for single steps, R4 R5 for chunked runs
      for (int i = 0; i < NV; i++) begin
         if (V_MODE[i] == 0) begin
            do_single(V_VI[i], V_G[i], V_Q[i]);
            model_step(longint'(V_G[i]), 20, V_VI[i], V_Q[i]);
            chk_nodes("R2 R3 single");
         end else begin
            do_run(V_VI[i], V_G[i], V_Q[i], V_N[i], nb);
            model_run(longint'(V_G[i]), V_N[i], V_VI[i], V_Q[i]);
            chk_nodes("R4 R5 run");
            chk("R4 busy clocks", nb, (V_N[i] + 7) / 8);
            chk("R9 done at end", longint'(done), 1);
         end
      end

      // R9 done is a single pulse, nodes then hold (R10)
      @(negedge clk);
      chk("R9 done pulse", longint'(done), 0);
      chk_nodes("R10 hold");

      // R7 start and strobe ignored while busy
      vi = 300; w0_dt_coef = 16'd2500; q_coef = 16'd900; cycles = 16'd24; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      vi = -9999; w0_dt_coef = 16'd60000; cycles = 16'd5; start = 1'b1;
      w0 = 24'd5000000; step_strobe = 1'b1;
      @(negedge clk);
      start = 1'b0; step_strobe = 1'b0;
      nb = 2;
      while (busy && nb < 100) begin nb++; @(negedge clk); end
      model_run(2500, 24, 300, 900);
      chk("R7 busy clocks", nb, 3);
      chk_nodes("R7 ignored start");

      // R9 zero count: done next edge, nodes unchanged; same-cycle strobe ignored (R7)
      @(negedge clk);
      vi = 77; w0 = 24'd900000; q_coef = 16'd1000; cycles = 16'd0;
      start = 1'b1; step_strobe = 1'b1;
      @(negedge clk);
      start = 1'b0; step_strobe = 1'b0;
      chk("R9 zero done", longint'(done), 1);
      chk("R9 zero busy", longint'(busy), 0);
      chk_nodes("R9 R7 zero count");

      // R6 enable low aborts a run and zeroes nodes
      @(negedge clk);
      vi = 400; w0_dt_coef = 16'd3000; q_coef = 16'd1024; cycles = 16'd40; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      m_hp = 0; m_bp = 0; m_lp = 0;
      chk("R6 busy", longint'(busy), 0);
      chk_nodes("R6 cleared");
      enable = 1'b1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk("R6 no done", longint'(done), 0);
      end
      chk_nodes("R10 hold after abort");

      // R1 reset clears nonzero state
      do_single(1000, 0, 1024);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      m_hp = 0; m_bp = 0; m_lp = 0;
      chk_nodes("R1 reset clears");

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule